// File: doc/BRIEF.md
# Address Bus GPIO Pin Multiplexer

This block sits between a memory controller and the sixteen pads of an external address bus. Each pad can carry an address bit from the controller, or it can be handed over to software as a general-purpose I/O. Three 16-bit registers control this per bit. The enable register picks address or GPIO. The direction register picks input or output for a GPIO pin. The data register holds the level driven on output pins and returns the pad level for input pins.

A handover only takes effect while the 2-bit parallel-port mode input is 00 or 11. In modes 01 and 10, every pad carries the address, whatever the enable register holds. Software reaches the registers through a simple synchronous port: writes take effect at the next clock edge, and reads return data one cycle after the read strobe. Pad input levels pass through a two-flop synchronizer before they can be read. A parameter removes the top two pins for the smaller package option.

Top module: `addr_gpio_mux`

## Requirements
- R1: Register select 0 is the enable register, 1 the direction register and 2 the data latch. A write with `reg_we` updates the selected register at the next rising clock edge. A read with `reg_rd` presents the value on `reg_rdata` after the next rising edge. Select 3 reads 0, and writes to it change no register.
- R2: A pin whose enable bit is 0 drives `pin_out` from `mc_addr` and drives `pin_oe` from `mc_addr_oe`.
- R3: When `bus_mode` is 01 or 10, every pin follows `mc_addr` and `mc_addr_oe`, whatever the enable bits hold. Modes 00 and 11 both permit a handover.
- R4: After reset, all three registers read 0 and every pin is in address mode.
- R5: A pin that is handed over and has direction bit 0 is an input, with `pin_oe` low.
- R6: A pin that is handed over and has direction bit 1 has `pin_oe` high, and `pin_out` equals its data latch bit (0 low, 1 high).
- R7: Reading select 2 returns, for each bit whose direction bit is 0, the level of `pin_in` through a two-flop synchronizer. A pad change is invisible to a read strobe issued at the second rising edge after the change, and visible to one issued at the third.
- R8: Reading select 2 returns the latch value for each bit whose direction bit is 1. The latch keeps its value while the pin is an input, and it drives that value again once the pin is switched back to output.
- R9: With `HAS_TOP_PAIR` = 0, bits 15 and 14 of all registers read 0 and ignore writes, and pins 15 and 14 always stay in address mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select (0 enable, 1 direction, 2 data, 3 none) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| bus_mode | input | 2 | Parallel-port mode; 00 or 11 permits handover |
| mc_addr | input | 16 | Address from the memory controller |
| mc_addr_oe | input | 1 | Bus-drive signal from the memory controller |
| pin_out | output | 16 | Per-pad output level |
| pin_oe | output | 16 | Per-pad output enable |
| pin_in | input | 16 | Per-pad input level |

## Verification
On every cycle, the assertions check the pad mux against the registers and the mode. They check that a blocked mode forces every pad to address, that output pins drive their latch bit, and that input pins are not driven. They also check that writes land one edge later with absent bits cleared, and that the synchronizer output trails the pad input by exactly two edges. The bench scenarios are needed for what depends on a sequence: the reset values seen through reads, the exact read-strobe cycle at which a pad change first appears, a latch surviving an input period, mode 11 acting like mode 00, and the reduced-pin variant.

// File: rtl/agm_pkg.sv
package agm_pkg;

  localparam int MODE_W      = 2;
  localparam int SEL_W       = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_EN   = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DAT  = 2'd2,
    SEL_NONE = 2'd3
  } agm_sel_e;

  // handover is allowed only in the two permitting bus modes
  function automatic logic mode_permits(input logic [MODE_W-1:0] mode);
    return (mode == 2'b00) || (mode == 2'b11);
  endfunction

  // per-bit readback of the data register: latch for outputs, pad for inputs
  function automatic logic data_view(input logic dir, input logic latch, input logic pad);
    return dir ? latch : pad;
  endfunction

endpackage

// File: rtl/agm_regs.sv
module agm_regs
  import agm_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] LIVE_MASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  agm_sel_e       sel,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   en_q,
  output logic [W-1:0]   dir_q,
  output logic [W-1:0]   dat_q
);

  logic [W-1:0] wmasked;
  logic         wr_en, wr_dir, wr_dat;

  assign wmasked = wdata & LIVE_MASK;
  assign wr_en   = we && (sel == SEL_EN);
  assign wr_dir  = we && (sel == SEL_DIR);
  assign wr_dat  = we && (sel == SEL_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wmasked;
      if (wr_dir) dir_q <= wmasked;
      if (wr_dat) dat_q <= wmasked;
    end
  end

  // R1: a write lands at the next edge with absent bits cleared
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == ($past(wdata) & LIVE_MASK));

  // R1: an unselected register holds across a write
  assert_dir_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel != SEL_DIR) |=> $stable(dir_q));

  // R9: absent bits never become set
  assert_absent_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | dir_q | dat_q) & ~LIVE_MASK) == '0);

endmodule

// File: rtl/agm_sync.sv
module agm_sync
  import agm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[SYNC_STAGES-1];

  // cycles since reset, saturating, so the latency check looks only at post-reset history
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R7: the synchronized value trails the pad by exactly two edges
  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> q == $past(d, 2));

endmodule

// File: rtl/agm_pin_mux.sv
module agm_pin_mux #(
  parameter int W = 16
) (
  input  logic         permit,
  input  logic [W-1:0] en_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] mc_addr,
  input  logic         mc_addr_oe,
  output logic [W-1:0] gpio_sel,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign gpio_sel[i] = en_q[i] & permit;
      assign pin_out[i]  = gpio_sel[i] ? dat_q[i] : mc_addr[i];
      assign pin_oe[i]   = gpio_sel[i] ? dir_q[i] : mc_addr_oe;
    end
  endgenerate

endmodule

// File: rtl/agm_readback.sv
module agm_readback
  import agm_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] LIVE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  agm_sel_e     sel,
  input  logic [W-1:0] en_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] rdata
);

  logic [W-1:0] dat_view;
  logic [W-1:0] rd_next;

  generate
    for (genvar i = 0; i < W; i++) begin : g_view
      assign dat_view[i] = data_view(dir_q[i], dat_q[i], pad_sync[i]) & LIVE_MASK[i];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_EN:  rd_next = en_q;
      SEL_DIR: rd_next = dir_q;
      SEL_DAT: rd_next = dat_view;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  // R1: the unused select returns zero
  assert_none_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> rdata == '0);

  // R9: absent bits never appear on the read port
  assert_rdata_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~LIVE_MASK) == '0);

endmodule

// File: rtl/addr_gpio_mux.sv
module addr_gpio_mux
  import agm_pkg::*;
#(
  parameter int NPINS        = 16,
  parameter bit HAS_TOP_PAIR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [MODE_W-1:0] bus_mode,
  input  logic [NPINS-1:0]  mc_addr,
  input  logic              mc_addr_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  pin_in
);

  localparam logic [NPINS-1:0] LIVE_MASK =
    HAS_TOP_PAIR ? {NPINS{1'b1}} : {2'b00, {(NPINS-2){1'b1}}};

  agm_sel_e         sel;
  logic             permit;
  logic [NPINS-1:0] en_q, dir_q, dat_q;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] gpio_sel;

  assign sel    = agm_sel_e'(reg_sel);
  assign permit = mode_permits(bus_mode);

  agm_regs #(.W(NPINS), .LIVE_MASK(LIVE_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(sel), .wdata(reg_wdata),
    .en_q(en_q), .dir_q(dir_q), .dat_q(dat_q)
  );

  agm_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
  );

  agm_pin_mux #(.W(NPINS)) u_mux (
    .permit(permit), .en_q(en_q), .dir_q(dir_q), .dat_q(dat_q),
    .mc_addr(mc_addr), .mc_addr_oe(mc_addr_oe),
    .gpio_sel(gpio_sel), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  agm_readback #(.W(NPINS), .LIVE_MASK(LIVE_MASK)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .sel(sel),
    .en_q(en_q), .dir_q(dir_q), .dat_q(dat_q), .pad_sync(pad_sync),
    .rdata(reg_rdata)
  );

  // R3: a blocked mode puts every pad on the address
  assert_blocked_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'b01 || bus_mode == 2'b10) |->
      (pin_out == mc_addr && pin_oe == {NPINS{mc_addr_oe}}));

  // R6: an output GPIO pad drives its latch bit
  assert_gpio_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ dat_q) & gpio_sel & dir_q) == '0);

  // R5: an input GPIO pad is never driven
  assert_gpio_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & gpio_sel & ~dir_q) == '0);

  // R2: a pad whose enable bit is clear follows the controller
  assert_addr_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ mc_addr) & ~en_q) == '0);

  // R4: the first cycle out of reset has no handover
  assert_reset_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> gpio_sel == '0);

  // R9: absent pads are never handed over
  assert_top_pair_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_sel & ~LIVE_MASK) == '0);

endmodule

// File: tb/addr_gpio_mux_test.sv
`timescale 1ns/1ps
module addr_gpio_mux_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  bus_mode = 2'b00;
  logic [15:0] mc_addr = 16'hA5C3;
  logic        mc_addr_oe = 1'b1;
  logic [15:0] pin_in = 16'h5A5A;
  logic [15:0] rdata, pout, poe;
  logic [15:0] rdata_l, pout_l, poe_l;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_gpio_mux #(.NPINS(16), .HAS_TOP_PAIR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .bus_mode(bus_mode), .mc_addr(mc_addr),
    .mc_addr_oe(mc_addr_oe), .pin_out(pout), .pin_oe(poe), .pin_in(pin_in));

  addr_gpio_mux #(.NPINS(16), .HAS_TOP_PAIR(1'b0)) uut_lite (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .bus_mode(bus_mode), .mc_addr(mc_addr),
    .mc_addr_oe(mc_addr_oe), .pin_out(pout_l), .pin_oe(poe_l), .pin_in(pin_in));

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // model: handover when enabled and mode is 00 or 11
  function automatic logic [15:0] m_out(input logic [15:0] en, input logic [1:0] mode,
                                        input logic [15:0] dat);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = (en[i] && (mode == 2'b00 || mode == 2'b11)) ? dat[i] : mc_addr[i];
    return r;
  endfunction

  function automatic logic [15:0] m_oe(input logic [15:0] en, input logic [1:0] mode,
                                       input logic [15:0] dir);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = (en[i] && (mode == 2'b00 || mode == 2'b11)) ? dir[i] : mc_addr_oe;
    return r;
  endfunction

  task automatic t_reset;
    check("R4", "oe after reset", poe, 16'hFFFF);
    check("R4", "out after reset", pout, mc_addr);
    rd(2'd0); check("R4", "enable reads 0", rdata, 16'h0000);
    rd(2'd1); check("R4", "direction reads 0", rdata, 16'h0000);
  endtask

  task automatic t_regs;
    wr(2'd1, 16'h1234); rd(2'd1); check("R1", "direction readback", rdata, 16'h1234);
    wr(2'd3, 16'hFFFF); rd(2'd3); check("R1", "select 3 reads 0", rdata, 16'h0000);
    rd(2'd1); check("R1", "select 3 write ignored", rdata, 16'h1234);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_gpio;
    bus_mode = 2'b00;
    wr(2'd1, 16'h0F0F); wr(2'd2, 16'h3C3C); wr(2'd0, 16'h00FF);
    @(negedge clk);
    check("R6", "gpio out mode00", pout, m_out(16'h00FF, 2'b00, 16'h3C3C));
    check("R5", "gpio oe mode00", poe, m_oe(16'h00FF, 2'b00, 16'h0F0F));
    check("R2", "high pins address", pout & 16'hFF00, mc_addr & 16'hFF00);
    mc_addr_oe = 1'b0; @(negedge clk);
    check("R2", "high pins follow bus drive", poe & 16'hFF00, 16'h0000);
    mc_addr_oe = 1'b1;
  endtask

  task automatic t_modes;
    bus_mode = 2'b01; @(negedge clk);
    check("R3", "mode01 out", pout, mc_addr);
    check("R3", "mode01 oe", poe, 16'hFFFF);
    bus_mode = 2'b10; @(negedge clk);
    check("R3", "mode10 out", pout, mc_addr);
    bus_mode = 2'b11; @(negedge clk);
    check("R3", "mode11 out", pout, m_out(16'h00FF, 2'b11, 16'h3C3C));
    check("R3", "mode11 oe", poe, m_oe(16'h00FF, 2'b11, 16'h0F0F));
    bus_mode = 2'b00;
  endtask

  task automatic t_readdata;
    pin_in = 16'h5A5A;
    repeat (3) @(negedge clk);
    rd(2'd2);
    check("R7", "mixed data read", rdata,
          (16'h0F0F & 16'h3C3C) | (~16'h0F0F & 16'h5A5A));
    check("R8", "output bits from latch", rdata & 16'h0F0F, 16'h3C3C & 16'h0F0F);
  endtask

  task automatic t_latency;
    @(negedge clk);
    pin_in = 16'hA5A5; reg_sel = 2'd2; reg_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7", "strobe at second edge sees old", rdata & 16'hF0F0, 16'h5A5A & 16'hF0F0);
    @(negedge clk);
    check("R7", "strobe at third edge sees new", rdata & 16'hF0F0, 16'hA5A5 & 16'hF0F0);
    reg_rd = 1'b0;
  endtask

  task automatic t_latch_hold;
    wr(2'd1, 16'h0000);
    @(negedge clk);
    check("R5", "all inputs oe", poe & 16'h00FF, 16'h0000);
    wr(2'd1, 16'h00FF);
    @(negedge clk);
    check("R8", "latch kept through input period", pout & 16'h00FF, 16'h003C);
    rd(2'd2);
    check("R8", "latch read back", rdata & 16'h00FF, 16'h003C);
  endtask

  task automatic t_lite;
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0000);
    rd(2'd0);
    check("R9", "lite enable top bits 0", rdata_l, 16'h3FFF);
    check("R1", "full enable all bits", rdata, 16'hFFFF);
    @(negedge clk);
    check("R9", "lite top pins address", pout_l & 16'hC000, mc_addr & 16'hC000);
    check("R9", "lite top pins oe", poe_l & 16'hC000, 16'hC000);
    check("R6", "full top pins gpio", pout & 16'hC000, 16'h0000);
    rd(2'd2);
    check("R9", "lite data top bits 0", rdata_l & 16'hC000, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_gpio;
    t_modes;
    t_readdata;
    t_latency;
    t_latch_hold;
    t_lite;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule